// File: doc/BRIEF.md
# Buffered Ready/Valid Stream Stage

This block sits between a word producer and a word consumer in a single clock domain, and both sides use a valid/ready handshake. The producer's words go into a circular store and leave in arrival order. Whenever at least one word is held, that word is offered downstream.

The upstream ready signal comes from a flop that is driven by an almost-full comparison. It therefore follows the fill level one clock late. The threshold sits low enough that the extra word accepted during that clock always has room.

Each side has a small classifier that records what its last clock edge saw:
- nothing offered,
- a completed transfer, or
- an offer that was stalled.

The fill level and the empty, full and almost-full flags are outputs. Reset is synchronous and active-low.

Top module: `rv_buf_stage`

## Requirements
- R1: On a clock edge with `rst_n` low, the stage becomes empty. The next cycle shows `level`=0, `empty`=1, `full`=0, `almost_full`=0, `in_ready`=0, `out_valid`=0, and both phase outputs at idle (0).
- R2: `in_ready` is a register. After every edge with `rst_n` high it equals the inverse of `almost_full` as it stood just before that edge.
- R3: The upstream side accepts a word on an edge only when `in_valid`, `in_ready` and not-`full` all hold. The downstream side releases a word on an edge only when `out_valid` and `out_ready` both hold. `level` rises by one for an accept alone, falls by one for a release alone, and is unchanged when both or neither happen.
- R4: `out_valid` is high exactly when `level` is non-zero, and `out_data` is the oldest stored word. Words leave in the order they were accepted.
- R5: `empty` is high at `level`=0. `full` is high at `level`=DEPTH. `almost_full` is high at `level`>=AF_LEVEL. The defaults are DEPTH 16 and AF_LEVEL 8.
- R6: While `out_valid` is high and `out_ready` is low, `out_valid` and `out_data` keep their values on the next cycle.
- R7: A word presented while `full` is high, or while `in_ready` is low, is not stored. Later output words show no trace of it.
- R8: Each phase output is registered. It reads 0 (idle) if valid was low at the last edge, 1 (transfer) if valid and ready were both high, and 2 (wait) if valid was high and ready low.
- R9: With AF_LEVEL below DEPTH, `level` never exceeds AF_LEVEL+1 while the producer obeys `in_ready`.
- R10: `out_valid` has no combinational dependence on `out_ready`, so changing `out_ready` within a cycle leaves `out_valid` unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Producer offers a word |
| in_data | input | DATA_W | Producer word |
| in_ready | output | 1 | Stage accepts words (registered) |
| out_valid | output | 1 | Stage offers its oldest word |
| out_data | output | DATA_W | Oldest stored word |
| out_ready | input | 1 | Consumer takes the offered word |
| level | output | CNT_W | Number of stored words, 0..DEPTH |
| empty | output | 1 | No word stored |
| full | output | 1 | DEPTH words stored |
| almost_full | output | 1 | At least AF_LEVEL words stored |
| in_phase | output | 2 | Upstream condition at last edge: 0 idle, 1 transfer, 2 wait |
| out_phase | output | 2 | Downstream condition at last edge: same encoding |

## Verification
The checker watches several behaviours on every cycle:
- how `level` steps for each accept/release combination,
- the one-cycle lag of `in_ready` behind `almost_full`,
- that the flags agree with `level`,
- that a stalled output word is held,
- the phase encoding, and
- the headroom bound.

Other behaviours only show up across the bench's scenarios:
- that the words leave in order and with intact values,
- that a write into a full store leaves no trace, and
- that `out_valid` does not move when `out_ready` flips within a cycle.

These scenarios run on two configurations. The first uses the default threshold. The second uses a four-deep store whose threshold equals its depth, so that the full flag and the ignored write become reachable.

// File: rtl/rvb_pkg.sv
// Package: shared types for the buffered ready/valid stage.
// Assumes: phase codes are visible at ports, so their values are fixed.
package rvb_pkg;
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_XFER = 2'd1,
        PH_WAIT = 2'd2
    } hs_phase_e;
endpackage

// File: rtl/rvb_store.sv
// Module: circular word store with read/write pointers and an occupancy count.
// Assumes: the caller never pushes into a full store and never pops an empty one.
// Contents are not reset; only the pointers and the count are.
module rvb_store #(
    parameter int DATA_W = 32,
    parameter int DEPTH  = 16,
    parameter int PTR_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    parameter int CNT_W  = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic              pop,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic [CNT_W-1:0]  count
);
    localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

    logic [DATA_W-1:0] mem [DEPTH];
    logic [PTR_W-1:0]  wr_ptr;
    logic [PTR_W-1:0]  rd_ptr;

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == LAST) ? '0 : p + PTR_W'(1);
    endfunction

    // Write the incoming word into the slot at the write pointer.
    always_ff @(posedge clk) begin
        if (push) mem[wr_ptr] <= wdata;
    end

    // Advance the pointers and track occupancy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) wr_ptr <= bump(wr_ptr);
            if (pop)  rd_ptr <= bump(rd_ptr);
            case ({push, pop})
                2'b10:   count <= count + CNT_W'(1);
                2'b01:   count <= count - CNT_W'(1);
                default: count <= count;
            endcase
        end
    end

    // Present the oldest word.
    assign rdata = mem[rd_ptr];
endmodule

// File: rtl/rvb_flags.sv
// Module: occupancy flags plus the registered upstream ready.
// Assumes: AF_LEVEL leaves at least one free slot for the word taken during the ready lag.
module rvb_flags #(
    parameter int DEPTH    = 16,
    parameter int AF_LEVEL = 8,
    parameter int CNT_W    = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] count,
    output logic             empty,
    output logic             full,
    output logic             almost_full,
    output logic             ready_q
);
    localparam logic [CNT_W-1:0] AF_CNT   = CNT_W'(AF_LEVEL);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

    // Decode the occupancy into flags.
    always_comb begin
        empty       = (count == '0);
        full        = (count == FULL_CNT);
        almost_full = (count >= AF_CNT);
    end

    // Register ready from the almost-full flag; low through reset.
    always_ff @(posedge clk) begin
        if (!rst_n) ready_q <= 1'b0;
        else        ready_q <= !almost_full;
    end
endmodule

// File: rtl/rvb_phase.sv
// Module: records the handshake condition one interface saw at the last clock edge.
// Assumes: valid and ready belong to the same interface and clock.
module rvb_phase
    import rvb_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      valid,
    input  logic      ready,
    output hs_phase_e phase
);
    // Classify the edge as idle, transfer or wait.
    always_ff @(posedge clk) begin
        if (!rst_n)     phase <= PH_IDLE;
        else if (!valid) phase <= PH_IDLE;
        else if (ready)  phase <= PH_XFER;
        else             phase <= PH_WAIT;
    end
endmodule

// File: rtl/rv_buf_stage.sv
// Module: buffered ready/valid stage. Words arrive upstream, wait in a circular
// store and leave downstream in order. out_valid depends only on stored state.
// Assumes: a single clock; the producer honours in_ready (writes are gated anyway).
module rv_buf_stage
    import rvb_pkg::*;
#(
    parameter int DATA_W   = 32,
    parameter int DEPTH    = 16,
    parameter int AF_LEVEL = 8,
    parameter int CNT_W    = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    output logic              in_ready,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data,
    input  logic              out_ready,
    output logic [CNT_W-1:0]  level,
    output logic              empty,
    output logic              full,
    output logic              almost_full,
    output logic [1:0]        in_phase,
    output logic [1:0]        out_phase
);
    logic      push;
    logic      pop;
    hs_phase_e in_ph;
    hs_phase_e out_ph;

    // Gate the transfers by their handshakes; full blocks writes.
    always_comb begin
        push      = in_valid && in_ready && !full;
        out_valid = !empty;
        pop       = out_valid && out_ready;
    end

    rvb_store #(.DATA_W(DATA_W), .DEPTH(DEPTH), .CNT_W(CNT_W)) u_store (
        .clk(clk), .rst_n(rst_n), .push(push), .pop(pop),
        .wdata(in_data), .rdata(out_data), .count(level)
    );

    rvb_flags #(.DEPTH(DEPTH), .AF_LEVEL(AF_LEVEL), .CNT_W(CNT_W)) u_flags (
        .clk(clk), .rst_n(rst_n), .count(level), .empty(empty),
        .full(full), .almost_full(almost_full), .ready_q(in_ready)
    );

    rvb_phase u_in_phase (
        .clk(clk), .rst_n(rst_n), .valid(in_valid), .ready(in_ready), .phase(in_ph)
    );

    rvb_phase u_out_phase (
        .clk(clk), .rst_n(rst_n), .valid(out_valid), .ready(out_ready), .phase(out_ph)
    );

    assign in_phase  = in_ph;
    assign out_phase = out_ph;
endmodule

// File: rtl/rvb_stage_chk.sv
// Module: property checker for rv_buf_stage, attached by bind below.
module rvb_stage_chk #(
    parameter int DATA_W   = 32,
    parameter int DEPTH    = 16,
    parameter int AF_LEVEL = 8,
    parameter int CNT_W    = $clog2(DEPTH + 1)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic              in_ready,
    input logic              out_valid,
    input logic [DATA_W-1:0] out_data,
    input logic              out_ready,
    input logic [CNT_W-1:0]  level,
    input logic              empty,
    input logic              full,
    input logic              almost_full,
    input logic [1:0]        in_phase,
    input logic [1:0]        out_phase
);
    logic acc;
    logic rel;
    assign acc = in_valid && in_ready && !full;
    assign rel = out_valid && out_ready;

    assert_level_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> level == $past(level) + CNT_W'($past(acc)) - CNT_W'($past(rel)));

    assert_ready_lag_R2: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> in_ready == !$past(almost_full));

    assert_hold_wait_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

    assert_valid_level_R4: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid == (level != '0));

    assert_flags_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (empty == (level == '0)) && (full == (level == CNT_W'(DEPTH)))
        && (almost_full == (level >= CNT_W'(AF_LEVEL))));

    assert_full_blocks_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (full && !out_ready) |=> full);

    assert_in_wait_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !in_ready) |=> in_phase == 2'd2);

    assert_out_xfer_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rel |=> out_phase == 2'd1);

    assert_reset_R1: assert property (@(posedge clk)
        !rst_n |=> (level == '0 && !in_ready && in_phase == 2'd0 && out_phase == 2'd0));

    generate
        if (AF_LEVEL < DEPTH) begin : g_headroom
            assert_headroom_R9: assert property (@(posedge clk) disable iff (!rst_n)
                level <= CNT_W'(AF_LEVEL + 1));
        end
    endgenerate
endmodule

bind rv_buf_stage rvb_stage_chk #(
    .DATA_W(DATA_W), .DEPTH(DEPTH), .AF_LEVEL(AF_LEVEL), .CNT_W(CNT_W)
) i_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .out_valid(out_valid), .out_data(out_data), .out_ready(out_ready),
    .level(level), .empty(empty), .full(full), .almost_full(almost_full),
    .in_phase(in_phase), .out_phase(out_phase)
);

// File: tb/test_rv_buf_stage.sv
`timescale 1ns/1ps
module test_rv_buf_stage;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic [7:0] in_data = '0;
    logic       out_ready = 1'b0;

    logic       a_ir, a_ov, a_em, a_fu, a_af;
    logic [7:0] a_od;
    logic [4:0] a_lv;
    logic [1:0] a_ip, a_op;
    logic       b_ir, b_ov, b_em, b_fu, b_af;
    logic [7:0] b_od;
    logic [2:0] b_lv;
    logic [1:0] b_ip, b_op;

    int tests = 0;
    int fails = 0;

    always #10 clk = ~clk;

    rv_buf_stage #(.DATA_W(8), .DEPTH(16), .AF_LEVEL(8)) i_rv_buf_stage (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .in_ready(a_ir), .out_valid(a_ov), .out_data(a_od), .out_ready(out_ready),
        .level(a_lv), .empty(a_em), .full(a_fu), .almost_full(a_af),
        .in_phase(a_ip), .out_phase(a_op)
    );

    rv_buf_stage #(.DATA_W(8), .DEPTH(4), .AF_LEVEL(4)) i_rv_buf_stage_small (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .in_ready(b_ir), .out_valid(b_ov), .out_data(b_od), .out_ready(out_ready),
        .level(b_lv), .empty(b_em), .full(b_fu), .almost_full(b_af),
        .in_phase(b_ip), .out_phase(b_op)
    );

    // Reference model, one slot per configuration (0: 16/8, 1: 4/4).
    logic [7:0] mm [2][16];
    int         hd [2];
    int         ct [2];
    logic       rm [2];
    logic [1:0] ipm [2];
    logic [1:0] opm [2];

    function automatic int dep(input int k);
        return (k == 0) ? 16 : 4;
    endfunction
    function automatic int afl(input int k);
        return (k == 0) ? 8 : 4;
    endfunction

    task automatic chk(input logic ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic chk_inst(input int k, input int lv, input logic em, input logic fu,
                            input logic af, input logic ir, input logic ov,
                            input logic [7:0] od, input logic [1:0] ip, input logic [1:0] op);
        chk(lv == ct[k], "R3 level", lv, ct[k]);
        chk(em == (ct[k] == 0), "R5 empty", int'(em), int'(ct[k] == 0));
        chk(fu == (ct[k] == dep(k)), "R5 full", int'(fu), int'(ct[k] == dep(k)));
        chk(af == (ct[k] >= afl(k)), "R5 almost_full", int'(af), int'(ct[k] >= afl(k)));
        chk(ir == rm[k], "R2 in_ready", int'(ir), int'(rm[k]));
        chk(ov == (ct[k] != 0), "R4 out_valid", int'(ov), int'(ct[k] != 0));
        if (ct[k] != 0)
            chk(od == mm[k][hd[k]], "R4 out_data order", int'(od), int'(mm[k][hd[k]]));
        chk(ip == ipm[k], "R8 in_phase", int'(ip), int'(ipm[k]));
        chk(op == opm[k], "R8 out_phase", int'(op), int'(opm[k]));
    endtask

    // One cycle: drive at negedge, check, update the model, cross the edge.
    task automatic step(input logic r, input logic v, input logic [7:0] d, input logic ordy);
        logic av, bv;
        rst_n = r; in_valid = v; in_data = d; out_ready = ordy;
        #1;
        chk_inst(0, int'(a_lv), a_em, a_fu, a_af, a_ir, a_ov, a_od, a_ip, a_op);
        chk_inst(1, int'(b_lv), b_em, b_fu, b_af, b_ir, b_ov, b_od, b_ip, b_op);
        av = a_ov; bv = b_ov;
        out_ready = !ordy;
        #1;
        chk(a_ov == av && b_ov == bv, "R10 valid vs ready", int'(a_ov), int'(av));
        out_ready = ordy;
        #1;
        for (int k = 0; k < 2; k++) begin
            logic pu, po;
            if (!r) begin
                hd[k] = 0; ct[k] = 0; rm[k] = 1'b0;
                ipm[k] = 2'd0; opm[k] = 2'd0;
            end else begin
                pu = v && rm[k] && (ct[k] < dep(k));
                po = (ct[k] != 0) && ordy;
                ipm[k] = !v ? 2'd0 : (rm[k] ? 2'd1 : 2'd2);
                opm[k] = (ct[k] == 0) ? 2'd0 : (ordy ? 2'd1 : 2'd2);
                rm[k]  = !(ct[k] >= afl(k));
                if (pu) mm[k][(hd[k] + ct[k]) % dep(k)] = d;
                if (po) hd[k] = (hd[k] + 1) % dep(k);
                ct[k] = ct[k] + int'(pu) - int'(po);
            end
        end
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        #(200000 * 20);
        fails++;
        $display("FAIL watchdog: actual 1 expected 0");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic [15:0] lfsr;
        logic [7:0]  seq;
        for (int k = 0; k < 2; k++) begin
            hd[k] = 0; ct[k] = 0; rm[k] = 1'b0; ipm[k] = 2'd0; opm[k] = 2'd0;
        end
        seq = 8'd1;
        @(negedge clk);
        // R1: reset cycles, then reset state observed.
        step(1'b0, 1'b1, 8'hAA, 1'b1);
        step(1'b0, 1'b0, 8'h00, 1'b0);
        chk(a_lv == 0 && a_em && !a_ir && !a_ov, "R1 reset state", int'(a_lv), 0);
        // R9/R7: fill with consumer stalled; the small store reaches full and sees writes while full.
        for (int i = 0; i < 24; i++) begin
            step(1'b1, 1'b1, seq, 1'b0);
            seq++;
        end
        chk(a_lv == 9, "R9 headroom level", int'(a_lv), 9);
        chk(b_fu == 1'b1, "R7 small store full", int'(b_fu), 1);
        // R6: stalled output stays stable.
        step(1'b1, 1'b0, 8'h00, 1'b0);
        chk(a_op == 2'd2, "R6 wait phase", int'(a_op), 2);
        // R4/R7: drain; the order shows no trace of ignored writes.
        for (int i = 0; i < 12; i++) step(1'b1, 1'b0, 8'h00, 1'b1);
        chk(a_em && b_em, "R4 drained", int'(a_lv), 0);
        // R3: continuous push and pop together.
        for (int i = 0; i < 40; i++) begin
            step(1'b1, 1'b1, seq, 1'b1);
            seq++;
        end
        // Pseudo-random sweep of valid, ready and data.
        lfsr = 16'hACE1;
        for (int i = 0; i < 4000; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            step(1'b1, lfsr[0] | lfsr[3], lfsr[15:8], lfsr[5] & (lfsr[1] | i[9]));
        end
        // R1: reset from a loaded state.
        for (int i = 0; i < 6; i++) step(1'b1, 1'b1, 8'h5A, 1'b0);
        step(1'b0, 1'b1, 8'h11, 1'b0);
        step(1'b1, 1'b0, 8'h00, 1'b0);
        chk(a_lv == 0 && b_lv == 0, "R1 mid-run reset", int'(a_lv), 0);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule